// File: doc/BRIEF.md
# Keyed write-unlock guard for a non-volatile memory engine

This block stands between a CPU register bus and a non-volatile memory engine. It stops accidental self-programming. Software must first write a two-byte key to a write-only key register, in a fixed order. It must then write the control register with its start bit set. Only when all of that holds does the guard send a one-cycle start pulse to the engine, together with the selected operation code.

From the accepted start until the engine reports completion, the guard holds a stall line to the CPU. The start bit reads back as 1 for that whole time. The guard refuses a start request in three cases: the key sequence was broken, the write-enable bit was not already stored, or the operation code is invalid. A refused start raises an error flag and leaves the engine untouched.

An interrupt-taken input counts as an interruption of the sequence and disarms it. The memory array, its timing and the interrupt gating itself live outside this block.

Top module: `nvm_unlock_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the key tracker idle, `stall` and `eng_start` low, `eng_op` zero, and every stored control bit (write enable, busy, error, operation) zero.
- R2: A key-register write (address 1) of 0x55 followed by a key-register write of 0xAA arms the guard. The two writes must have no other bus write between them, but cycles with no bus write may separate the steps. A 0x55 key write at any point restarts the sequence at its first step.
- R3: Three kinds of write disarm the guard back to idle: a key write of any other value, a key write of 0xAA that does not follow 0x55, and a write to any address other than the key register.
- R4: The control register sits at address 0. Bit 0 is write enable, bit 1 is start, bit 2 is the error flag (read only), and bits 6:4 are the operation code. A control write with bit 1 set is accepted only if three conditions hold: the guard is armed, write enable was already stored as 1 before that write, and the operation code is valid.
- R5: An accepted start makes `eng_start` high for exactly one cycle, the cycle after the write. In that same cycle `stall` goes high and `eng_op` carries the operation code from the start write.
- R6: `stall` stays high until `eng_done` is sampled high. It is low from the following cycle on. `eng_done` has no effect while the guard is not busy.
- R7: Control bit 1 reads back as 1 exactly while the operation is busy, and it clears itself on completion.
- R8: A refused start sets the error flag (control bit 2) and raises neither `eng_start` nor `stall`. The error flag is cleared by a control write without the start bit, or by an accepted start.
- R9: `irq_taken` sampled high returns the tracker to idle. A start write in that same cycle is refused.
- R10: While busy, every bus write is ignored. The stored control bits and `eng_op` do not change, and the tracker is idle when the operation ends.
- R11: Operation codes 0 to 4 select, in turn, row erase, write-latch load, latch-to-program-memory write, latch-to-user-ID write and data EEPROM write. Codes 5 to 7 are refused like a broken sequence.
- R12: Every control write stores write enable and the operation code. Every control write also returns the tracker to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe, one write per cycle |
| bus_addr | input | 4 | Register address (0 control, 1 key) |
| bus_wdata | input | 8 | Write data |
| irq_taken | input | 1 | Interrupt taken, disarms the sequence |
| eng_done | input | 1 | Engine reports completion |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_op | output | 3 | Operation code of the accepted start |
| stall | output | 1 | CPU stall while busy |
| ctrl_rdata | output | 8 | Control register readback |

## Verification
The checker watches several properties on every cycle. No start pulse may appear without an armed tracker and a start write in the preceding cycle. The start pulse is single and always coincides with stall. Stall holds until completion and drops right after it. A rising error flag never comes with stall. The operation code is frozen while busy. An interrupt always disarms the tracker. Only the bench scenarios can show the rest of the behaviour: which exact write orders arm the guard, that idle gaps are tolerated while foreign writes are not, that a write enable given in the start write itself is too late, that invalid codes are refused, and that writes made while busy leave no trace. A behavioural reference model compares all outputs on every cycle across those scenarios.

// File: rtl/nvm_unlock_pkg.sv
package nvm_unlock_pkg;

   typedef enum logic [1:0] {
      KT_IDLE  = 2'd0,
      KT_HALF  = 2'd1,
      KT_ARMED = 2'd2
   } key_state_t;

   // operation codes understood by the engine
   localparam int OP_ROW_ERASE   = 0;
   localparam int OP_LATCH_LOAD  = 1;
   localparam int OP_LATCH_PROG  = 2;
   localparam int OP_LATCH_UID   = 3;
   localparam int OP_DATA_EE     = 4;
   localparam int NUM_OPS        = 5;

endpackage

// File: rtl/nvm_key_tracker.sv
module nvm_key_tracker
   import nvm_unlock_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] KEY_A = 8'h55,
   parameter logic [DATA_W-1:0] KEY_B = 8'hAA
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              key_wr,
   input  logic              other_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              abort,
   input  logic              hold,
   output logic              armed
);

   key_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (hold || abort) begin
         st_d = KT_IDLE;
      end else if (key_wr) begin
         if (wdata == KEY_A)
            st_d = KT_HALF;
         else if (st_q == KT_HALF && wdata == KEY_B)
            st_d = KT_ARMED;
         else
            st_d = KT_IDLE;
      end else if (other_wr) begin
         st_d = KT_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= KT_IDLE;
      else     st_q <= st_d;
   end

   assign armed = (st_q == KT_ARMED);

endmodule

// File: rtl/nvm_ctrl_regs.sv
module nvm_ctrl_regs #(
   parameter int OP_W    = 3,
   parameter int NUM_OPS = 5
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ctrl_wr,
   input  logic            wr_wren,
   input  logic            wr_start,
   input  logic [OP_W-1:0] wr_op,
   input  logic            armed,
   input  logic            abort,
   output logic            accept,
   output logic            wren,
   output logic [OP_W-1:0] op,
   output logic            err
);

   localparam logic [OP_W-1:0] OP_LIMIT = OP_W'(NUM_OPS);

   logic op_ok;
   logic start_req;

   assign op_ok     = (wr_op < OP_LIMIT);
   assign start_req = ctrl_wr && wr_start;
   assign accept    = start_req && armed && !abort && wren && op_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         wren <= 1'b0;
         op   <= '0;
         err  <= 1'b0;
      end else if (ctrl_wr) begin
         wren <= wr_wren;
         op   <= wr_op;
         err  <= start_req && !accept;
      end
   end

endmodule

// File: rtl/nvm_op_seq.sv
module nvm_op_seq #(
   parameter int OP_W = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            accept,
   input  logic [OP_W-1:0] op_in,
   input  logic            done,
   output logic            busy,
   output logic            start_pulse,
   output logic [OP_W-1:0] op_out
);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy        <= 1'b0;
         start_pulse <= 1'b0;
         op_out      <= '0;
      end else begin
         start_pulse <= accept && !busy;
         if (busy) begin
            if (done) busy <= 1'b0;
         end else if (accept) begin
            busy   <= 1'b1;
            op_out <= op_in;
         end
      end
   end

endmodule

// File: rtl/nvm_unlock_ctrl.sv
module nvm_unlock_ctrl #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int OP_W      = 3,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h0,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'h1,
   parameter logic [DATA_W-1:0] KEY_A     = 8'h55,
   parameter logic [DATA_W-1:0] KEY_B     = 8'hAA,
   parameter int WREN_BIT  = 0,
   parameter int START_BIT = 1,
   parameter int ERR_BIT   = 2,
   parameter int OP_LSB    = 4,
   parameter bit IRQ_ABORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              irq_taken,
   input  logic              eng_done,
   output logic              eng_start,
   output logic [OP_W-1:0]   eng_op,
   output logic              stall,
   output logic [DATA_W-1:0] ctrl_rdata
);

   localparam int OP_MSB = OP_LSB + OP_W - 1;

   generate
      if (OP_MSB >= DATA_W) begin : g_bad_op_field
         $error("operation field does not fit the data width");
      end
      if (CTRL_ADDR == KEY_ADDR) begin : g_bad_addr
         $error("control and key registers share an address");
      end
      if ((1 << OP_W) < nvm_unlock_pkg::NUM_OPS) begin : g_bad_op_w
         $error("operation field too narrow");
      end
   endgenerate

   logic abort;
   logic armed;
   logic busy;
   logic accept;
   logic wren;
   logic err;
   logic [OP_W-1:0] op;
   logic key_wr, ctrl_wr, other_wr;

   generate
      if (IRQ_ABORT) begin : g_irq_abort
         assign abort = irq_taken;
      end else begin : g_irq_ignore
         assign abort = 1'b0;
      end
   endgenerate

   assign key_wr   = bus_we && !busy && (bus_addr == KEY_ADDR);
   assign ctrl_wr  = bus_we && !busy && (bus_addr == CTRL_ADDR);
   assign other_wr = bus_we && !busy && (bus_addr != KEY_ADDR);

   nvm_key_tracker #(
      .DATA_W (DATA_W),
      .KEY_A  (KEY_A),
      .KEY_B  (KEY_B)
   ) i_tracker (
      .clk      (clk),
      .rst      (rst),
      .key_wr   (key_wr),
      .other_wr (other_wr),
      .wdata    (bus_wdata),
      .abort    (abort),
      .hold     (busy),
      .armed    (armed)
   );

   nvm_ctrl_regs #(
      .OP_W    (OP_W),
      .NUM_OPS (nvm_unlock_pkg::NUM_OPS)
   ) i_regs (
      .clk      (clk),
      .rst      (rst),
      .ctrl_wr  (ctrl_wr),
      .wr_wren  (bus_wdata[WREN_BIT]),
      .wr_start (bus_wdata[START_BIT]),
      .wr_op    (bus_wdata[OP_MSB:OP_LSB]),
      .armed    (armed),
      .abort    (abort),
      .accept   (accept),
      .wren     (wren),
      .op       (op),
      .err      (err)
   );

   nvm_op_seq #(
      .OP_W (OP_W)
   ) i_seq (
      .clk         (clk),
      .rst         (rst),
      .accept      (accept),
      .op_in       (bus_wdata[OP_MSB:OP_LSB]),
      .done        (eng_done),
      .busy        (busy),
      .start_pulse (eng_start),
      .op_out      (eng_op)
   );

   assign stall = busy;

   always_comb begin
      ctrl_rdata                  = '0;
      ctrl_rdata[WREN_BIT]        = wren;
      ctrl_rdata[START_BIT]       = busy;
      ctrl_rdata[ERR_BIT]         = err;
      ctrl_rdata[OP_MSB:OP_LSB]   = op;
   end

endmodule

// File: rtl/nvm_unlock_chk.sv
module nvm_unlock_chk #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int OP_W      = 3,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h0,
   parameter int START_BIT = 1,
   parameter bit IRQ_ABORT = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              irq_taken,
   input logic              eng_done,
   input logic              eng_start,
   input logic [OP_W-1:0]   eng_op,
   input logic              stall,
   input logic              armed,
   input logic              busy,
   input logic              err
);

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!stall && !eng_start && !armed && !err));

   a_r4_start_needs_arm: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(armed && bus_we && bus_addr == CTRL_ADDR && bus_wdata[START_BIT]));

   a_r5_pulse_with_stall: assert property (@(posedge clk) disable iff (rst)
      eng_start |-> stall);

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
      eng_start |=> !eng_start);

   a_r6_stall_holds: assert property (@(posedge clk) disable iff (rst)
      (stall && !eng_done) |=> stall);

   a_r6_stall_release: assert property (@(posedge clk) disable iff (rst)
      (stall && eng_done) |=> !stall);

   a_r8_reject_no_stall: assert property (@(posedge clk) disable iff (rst)
      $rose(err) |-> (!stall && !eng_start));

   a_r10_op_frozen: assert property (@(posedge clk) disable iff (rst)
      stall |=> (!stall || $stable(eng_op)));

   generate
      if (IRQ_ABORT) begin : g_irq_chk
         a_r9_irq_disarms: assert property (@(posedge clk) disable iff (rst)
            irq_taken |=> !armed);
      end
   endgenerate

endmodule

bind nvm_unlock_ctrl nvm_unlock_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .OP_W      (OP_W),
   .CTRL_ADDR (CTRL_ADDR),
   .START_BIT (START_BIT),
   .IRQ_ABORT (IRQ_ABORT)
) i_chk (
   .clk       (clk),
   .rst       (rst),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_taken (irq_taken),
   .eng_done  (eng_done),
   .eng_start (eng_start),
   .eng_op    (eng_op),
   .stall     (stall),
   .armed     (armed),
   .busy      (busy),
   .err       (err)
);

// File: tb/test_nvm_unlock_ctrl.sv
module test_nvm_unlock_ctrl;

   localparam logic [3:0] CA = 4'h0;
   localparam logic [3:0] KA = 4'h1;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bus_we = 1'b0;
   logic [3:0] bus_addr = 4'h0;
   logic [7:0] bus_wdata = 8'h00;
   logic       irq_taken = 1'b0;
   logic       eng_done = 1'b0;
   logic       eng_start;
   logic [2:0] eng_op;
   logic       stall;
   logic [7:0] ctrl_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   nvm_unlock_ctrl i_nvm_unlock_ctrl (
      .clk        (clk),
      .rst        (rst),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .irq_taken  (irq_taken),
      .eng_done   (eng_done),
      .eng_start  (eng_start),
      .eng_op     (eng_op),
      .stall      (stall),
      .ctrl_rdata (ctrl_rdata)
   );

   // behavioural reference model
   int m_key = 0;      // 0 idle, 1 first key seen, 2 armed
   bit m_wren, m_err, m_busy, m_pulse;
   int m_op = 0;
   int m_eop = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_key = 0; m_wren = 0; m_err = 0; m_busy = 0; m_pulse = 0;
         m_op = 0; m_eop = 0;
      end else begin
         m_pulse = 0;
         if (m_busy) begin
            m_key = 0;
            if (eng_done) m_busy = 0;
         end else if (bus_we && bus_addr == KA) begin
            if (irq_taken) m_key = 0;
            else if (bus_wdata == 8'h55) m_key = 1;
            else if (m_key == 1 && bus_wdata == 8'hAA) m_key = 2;
            else m_key = 0;
         end else if (bus_we && bus_addr == CA) begin
            int wop;
            wop = int'(bus_wdata[6:4]);
            if (bus_wdata[1]) begin
               if (m_key == 2 && !irq_taken && m_wren && wop < 5) begin
                  m_busy = 1; m_pulse = 1; m_eop = wop; m_err = 0;
               end else m_err = 1;
            end else m_err = 0;
            m_wren = bus_wdata[0];
            m_op = wop;
            m_key = 0;
         end else if (bus_we || irq_taken) begin
            m_key = 0;
         end
      end
   end

   function automatic logic [7:0] model_rdata();
      logic [7:0] r;
      r = 8'h00;
      r[0] = m_wren; r[1] = m_busy; r[2] = m_err; r[6:4] = 3'(m_op);
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   bit cmp_en = 1'b0;
   always @(negedge clk) begin
      if (cmp_en) begin
         chk(stall == m_busy, "R6 model stall", int'(stall), int'(m_busy));
         chk(eng_start == m_pulse, "R5 model eng_start", int'(eng_start), int'(m_pulse));
         chk(int'(eng_op) == m_eop, "R5 model eng_op", int'(eng_op), m_eop);
         chk(ctrl_rdata == model_rdata(), "R7 model ctrl_rdata",
             int'(ctrl_rdata), int'(model_rdata()));
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit irq = 1'b0);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; irq_taken = irq;
      @(negedge clk);
      bus_we = 1'b0; irq_taken = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic done_pulse();
      @(negedge clk);
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
   endtask

   task automatic irq_pulse();
      @(negedge clk);
      irq_taken = 1'b1;
      @(negedge clk);
      irq_taken = 1'b0;
   endtask

   // after a start write: accepted or refused?
   task automatic expect_start(input bit acc, input int op, input string req);
      chk(eng_start == acc, req, int'(eng_start), int'(acc));
      chk(stall == acc, req, int'(stall), int'(acc));
      chk(ctrl_rdata[2] == !acc, {req, " err"}, int'(ctrl_rdata[2]), int'(!acc));
      if (acc) chk(int'(eng_op) == op, {req, " op"}, int'(eng_op), op);
      @(negedge clk);
      chk(eng_start == 1'b0, {req, " pulse width"}, int'(eng_start), 0);
      if (acc) done_pulse();
   endtask

   initial begin
      idle(3);
      @(negedge clk);
      rst = 1'b0;
      chk(stall == 0 && eng_start == 0 && ctrl_rdata == 8'h00 && eng_op == 0,
          "R1 reset state", int'(ctrl_rdata), 0);
      cmp_en = 1'b1;

      // R2/R5/R6/R7: full sequence, data EEPROM write
      wr(CA, 8'h41);
      wr(KA, 8'h55); wr(KA, 8'hAA); wr(CA, 8'h43);
      chk(eng_start == 1, "R5 start pulse", int'(eng_start), 1);
      chk(eng_op == 3'd4, "R11 op data EEPROM", int'(eng_op), 4);
      chk(ctrl_rdata[1] == 1, "R7 start reads 1", int'(ctrl_rdata[1]), 1);
      idle(4);
      chk(stall == 1, "R6 stall held", int'(stall), 1);
      done_pulse();
      chk(stall == 0, "R6 stall released", int'(stall), 0);
      chk(ctrl_rdata[1] == 0, "R7 start self clears", int'(ctrl_rdata[1]), 0);

      // R4/R8: start without keys
      wr(CA, 8'h03); expect_start(0, 0, "R4 no keys");
      wr(CA, 8'h01);
      chk(ctrl_rdata[2] == 0, "R8 err cleared", int'(ctrl_rdata[2]), 0);

      // R3: wrong key value in between
      wr(KA, 8'h55); wr(KA, 8'h12); wr(KA, 8'hAA); wr(CA, 8'h03);
      expect_start(0, 0, "R3 wrong key");
      // R12/R3: control write between keys
      wr(KA, 8'h55); wr(CA, 8'h01); wr(KA, 8'hAA); wr(CA, 8'h03);
      expect_start(0, 0, "R12 ctrl write breaks");
      // R3: foreign address between keys
      wr(KA, 8'h55); wr(4'h5, 8'h00); wr(KA, 8'hAA); wr(CA, 8'h03);
      expect_start(0, 0, "R3 other address");
      // R3: 0xAA alone
      wr(KA, 8'hAA); wr(CA, 8'h03);
      expect_start(0, 0, "R3 lone second key");

      // R2: idle gaps allowed, row erase
      wr(CA, 8'h01);
      wr(KA, 8'h55); idle(3); wr(KA, 8'hAA); idle(2); wr(CA, 8'h03);
      expect_start(1, 0, "R2 gaps allowed");
      // R2: repeated first key restarts
      wr(KA, 8'h55); wr(KA, 8'h55); wr(KA, 8'hAA); wr(CA, 8'h13);
      expect_start(1, 1, "R2 restart on first key");
      // R11: remaining valid codes
      wr(KA, 8'h55); wr(KA, 8'hAA); wr(CA, 8'h23); expect_start(1, 2, "R11 op 2");
      wr(KA, 8'h55); wr(KA, 8'hAA); wr(CA, 8'h33); expect_start(1, 3, "R11 op 3");
      // R11: invalid codes
      wr(KA, 8'h55); wr(KA, 8'hAA); wr(CA, 8'h63); expect_start(0, 0, "R11 op 6");
      wr(KA, 8'h55); wr(KA, 8'hAA); wr(CA, 8'h53); expect_start(0, 0, "R11 op 5");

      // R9: interrupt mid sequence, and with the start write
      wr(CA, 8'h01);
      wr(KA, 8'h55); irq_pulse(); wr(KA, 8'hAA); wr(CA, 8'h03);
      expect_start(0, 0, "R9 irq between keys");
      wr(KA, 8'h55); wr(KA, 8'hAA); wr(CA, 8'h03, 1'b1);
      expect_start(0, 0, "R9 irq with start");

      // R4: enable given only in the start write is too late
      wr(CA, 8'h00);
      wr(KA, 8'h55); wr(KA, 8'hAA); wr(CA, 8'h03);
      expect_start(0, 0, "R4 enable not stored");
      chk(ctrl_rdata[0] == 1, "R12 enable stored", int'(ctrl_rdata[0]), 1);

      // R10: writes during busy ignored
      wr(KA, 8'h55); wr(KA, 8'hAA); wr(CA, 8'h13);
      wr(CA, 8'h20); wr(KA, 8'h55); wr(KA, 8'hAA);
      chk(ctrl_rdata == 8'h13, "R10 ctrl frozen", int'(ctrl_rdata), 8'h13);
      chk(eng_op == 3'd1, "R10 op frozen", int'(eng_op), 1);
      done_pulse();
      wr(CA, 8'h03);
      expect_start(0, 0, "R10 tracker idle after busy");

      // R6: done while idle has no effect
      done_pulse();
      chk(stall == 0 && eng_start == 0, "R6 stray done", int'(stall), 0);

      idle(3);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule